// File: doc/BRIEF.md
# Multi-Table UART Bit-Rate Enable Generator

This block makes the bit-rate enables for both channels of a two-channel UART. It runs from a 14.7456 MHz reference clock. Four directions each have their own 4-bit source code: channel 0 receive, channel 0 transmit, channel 1 receive and channel 1 transmit. Each channel's 8-bit select byte holds its receive code in the upper nibble and its transmit code in the lower nibble. Codes 0 to 12 index a rate table. That table is chosen by two extended-mode inputs together with an alternate-set input. Code 13 passes an internal timer tick through. Codes 14 and 15 use the direction's own external clock pin.

Each output is a one-reference-cycle enable pulse. Internal rates pulse at sixteen times the table's baud rate and are made by one fractional accumulator per direction. External pins are synchronized, and each rising edge gives one pulse. A per-direction flag marks a 1x source, which is code 15. The serializers use the enables together with the flag. Nothing downstream is ever clocked by a gated clock.

Top module: `baud_clock_sel`

## Requirements
- R1: While rst_n is low, bit_en and x1_mode read 0 whatever the selects, timer tick or pins are doing.
- R2: Direction index 0 takes its code from sel_ch0[7:4], index 1 from sel_ch0[3:0], index 2 from sel_ch1[7:4] and index 3 from sel_ch1[3:0]. Direction d uses pin ext_clk[d] and only that pin.
- R3: With both mode inputs low and set_alt low, codes 0 to 12 give 50, 110, 134.5, 200, 300, 600, 1200, 1050, 2400, 4800, 7200, 9600 and 38400 baud. The pulse count over any window is within one pulse of 16 × baud × window / 14.7456 MHz.
- R4: With both mode inputs low and set_alt high, codes 0 to 12 give 75, 110, 134.5, 150, 300, 600, 1200, 2000, 2400, 4800, 1800, 9600 and 19200 baud, to the same accuracy.
- R5: With ext_mode1 high and ext_mode2 low, codes 0 to 12 give 300, 110, 134.5, 1200, 1800, 3600, 7200, 1050, 14400, 28800, 7200, 57600 and 230400 baud (set_alt low). They give 450, 110, 134.5, 900, 1800, 3600, 7200, 2000, 14400, 28800, 1800, 57600 and 115200 baud (set_alt high).
- R6: With ext_mode2 high, whatever ext_mode1 is, codes 0 to 12 give 4800, 880, 1076, 19200, 28800, 57600, 115200, 1050, 57600, 4800, 57600, 9600 and 38400 baud (set_alt low). They give 7200, 880, 1076, 14400, 28800, 57600, 115200, 2000, 57600, 4800, 14400, 9600 and 19200 baud (set_alt high).
- R7: Code 13 makes bit_en[d] equal to timer_tick one cycle later, in every mode and set.
- R8: Code 14 gives exactly one bit_en[d] pulse for each rising edge on ext_clk[d], within three cycles of the edge. A pin held high gives no further pulses.
- R9: Code 15 uses the pin as in R8. x1_mode[d] is high one cycle after the code is 15 and low one cycle after any other code.
- R10: An internal-rate enable is never high in two consecutive cycles.
- R11: A change of code takes effect at the next reference edge. From that edge on, bit_en[d] comes only from the newly selected source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 14.7456 MHz reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_ch0 | input | 8 | Channel 0 select: [7:4] receive code, [3:0] transmit code |
| sel_ch1 | input | 8 | Channel 1 select: [7:4] receive code, [3:0] transmit code |
| set_alt | input | 1 | Chooses the alternate rate column |
| ext_mode1 | input | 1 | Enables the first extended rate table |
| ext_mode2 | input | 1 | Enables the second extended rate table (wins over ext_mode1) |
| timer_tick | input | 1 | Internal timer output, one-cycle pulses |
| ext_clk | input | 4 | External clock pins, one per direction |
| bit_en | output | 4 | Per-direction bit-rate enable pulses |
| x1_mode | output | 4 | High when the direction's source is 1x |

## Verification
Six rate patterns are applied, each setting four different codes at once. They cover the normal, first-extended and second-extended tables in both sets, and the last one has both mode inputs high. Because the same code gives different rates across these patterns, a wrong column, a lost mode precedence or a swapped nibble shows up as a count outside its window. Pins are pulsed one at a time to separate the four pin routes, and then held high to prove edge detection rather than level sensing. The timer pass-through and a live switch away from a busy timer source show the one-cycle latency, and show that nothing of the old source carries over.

// File: rtl/baud_sel_pkg.sv
package baud_sel_pkg;

  typedef enum logic [1:0] {TBL_NORM = 2'd0, TBL_EXT1 = 2'd1, TBL_EXT2 = 2'd2} tbl_e;

  localparam logic [3:0] CODE_TIMER = 4'd13;
  localparam logic [3:0] CODE_PIN16 = 4'd14;
  localparam logic [3:0] CODE_PIN1  = 4'd15;

  function automatic tbl_e table_of(input logic m1, input logic m2);
    if (m2)      return TBL_EXT2;
    else if (m1) return TBL_EXT1;
    else         return TBL_NORM;
  endfunction

  // column 0..5 = table*2 + set
  function automatic int unsigned column_of(input tbl_e t, input logic alt);
    return 2 * int'(t) + (alt ? 1 : 0);
  endfunction

  function automatic int unsigned pick6(input int unsigned col,
                                        input int unsigned a, input int unsigned b,
                                        input int unsigned c, input int unsigned d,
                                        input int unsigned e, input int unsigned f);
    case (col)
      0: return a;
      1: return b;
      2: return c;
      3: return d;
      4: return e;
      default: return f;
    endcase
  endfunction

  // rate in units of half a baud, so that 134.5 and 1076 stay integral
  function automatic int unsigned half_baud(input logic [3:0] code, input int unsigned col);
    case (code)
      4'd0:  return pick6(col,   100,   150,    600,    900,   9600,  14400);
      4'd1:  return pick6(col,   220,   220,    220,    220,   1760,   1760);
      4'd2:  return pick6(col,   269,   269,    269,    269,   2152,   2152);
      4'd3:  return pick6(col,   400,   300,   2400,   1800,  38400,  28800);
      4'd4:  return pick6(col,   600,   600,   3600,   3600,  57600,  57600);
      4'd5:  return pick6(col,  1200,  1200,   7200,   7200, 115200, 115200);
      4'd6:  return pick6(col,  2400,  2400,  14400,  14400, 230400, 230400);
      4'd7:  return pick6(col,  2100,  4000,   2100,   4000,   2100,   4000);
      4'd8:  return pick6(col,  4800,  4800,  28800,  28800, 115200, 115200);
      4'd9:  return pick6(col,  9600,  9600,  57600,  57600,   9600,   9600);
      4'd10: return pick6(col, 14400,  3600,  14400,   3600, 115200,  28800);
      4'd11: return pick6(col, 19200, 19200, 115200, 115200,  19200,  19200);
      4'd12: return pick6(col, 76800, 38400, 460800, 230400,  76800,  38400);
      default: return 0;
    endcase
  endfunction

endpackage

// File: rtl/baud_accum.sv
module baud_accum #(
  parameter int unsigned MOD = 29491200,
  parameter int          W   = 26
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] step,
  output logic         pulse
);
  localparam logic [W:0] MOD_V = (W+1)'(MOD);

  logic [W-1:0] acc;
  logic [W:0]   sum;

  always_comb sum = {1'b0, acc} + {1'b0, step};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc   <= '0;
      pulse <= 1'b0;
    end else if (sum >= MOD_V) begin
      acc   <= W'(sum - MOD_V);
      pulse <= 1'b1;
    end else begin
      acc   <= sum[W-1:0];
      pulse <= 1'b0;
    end
  end
endmodule

// File: rtl/pin_edge.sv
module pin_edge #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic [SYNC_STAGES:0] shreg;

  always_ff @(posedge clk) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[SYNC_STAGES-1:0], pin};
  end

  assign rise = shreg[SYNC_STAGES-1] & ~shreg[SYNC_STAGES];
endmodule

// File: rtl/baud_clock_sel.sv
module baud_clock_sel #(
  parameter int unsigned REF_HZ = 14745600
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] sel_ch0,
  input  logic [7:0] sel_ch1,
  input  logic       set_alt,
  input  logic       ext_mode1,
  input  logic       ext_mode2,
  input  logic       timer_tick,
  input  logic [3:0] ext_clk,
  output logic [3:0] bit_en,
  output logic [3:0] x1_mode
);
  import baud_sel_pkg::*;

  localparam int          NDIR    = 4;
  localparam int unsigned ACC_MOD = 2 * REF_HZ;
  localparam int          ACC_W   = $clog2(ACC_MOD) + 1;

  logic [NDIR-1:0][3:0] dir_code;
  logic [NDIR-1:0]      rate_pulse;
  logic [NDIR-1:0]      ext_rise;
  logic [NDIR-1:0]      src_hit;
  logic [NDIR-1:0]      is_1x;
  int unsigned          col;

  assign dir_code[0] = sel_ch0[7:4];
  assign dir_code[1] = sel_ch0[3:0];
  assign dir_code[2] = sel_ch1[7:4];
  assign dir_code[3] = sel_ch1[3:0];

  always_comb col = column_of(table_of(ext_mode1, ext_mode2), set_alt);

  for (genvar d = 0; d < NDIR; d++) begin : g_dir
    logic [ACC_W-1:0] step;
    int unsigned      hb;

    always_comb begin
      hb   = half_baud(dir_code[d], col);
      step = (dir_code[d] < CODE_TIMER) ? ACC_W'(16 * hb) : '0;
    end

    baud_accum #(.MOD(ACC_MOD), .W(ACC_W)) u_acc (
      .clk  (clk),
      .rst_n(rst_n),
      .step (step),
      .pulse(rate_pulse[d])
    );

    pin_edge #(.SYNC_STAGES(2)) u_pin (
      .clk  (clk),
      .rst_n(rst_n),
      .pin  (ext_clk[d]),
      .rise (ext_rise[d])
    );

    always_comb begin
      if (dir_code[d] < CODE_TIMER)       src_hit[d] = rate_pulse[d];
      else if (dir_code[d] == CODE_TIMER) src_hit[d] = timer_tick;
      else                                src_hit[d] = ext_rise[d];
      is_1x[d] = (dir_code[d] == CODE_PIN1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_en  <= '0;
      x1_mode <= '0;
    end else begin
      bit_en  <= src_hit;
      x1_mode <= is_1x;
    end
  end
endmodule

// File: rtl/baud_sel_chk.sv
module baud_sel_chk (
  input logic            clk,
  input logic            rst_n,
  input logic            timer_tick,
  input logic [3:0][3:0] dir_code,
  input logic [3:0]      rate_pulse,
  input logic [3:0]      ext_rise,
  input logic [3:0]      bit_en,
  input logic [3:0]      x1_mode
);
  for (genvar d = 0; d < 4; d++) begin : g_chk
    AST_ONE_X_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      x1_mode[d] |-> $past(dir_code[d]) == 4'd15); // R9

    AST_TIMER_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_code[d] == 4'd13 && timer_tick) |=> bit_en[d]); // R7

    AST_SOURCE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      bit_en[d] |-> $past((dir_code[d] <  4'd13 && rate_pulse[d]) ||
                          (dir_code[d] == 4'd13 && timer_tick)    ||
                          (dir_code[d] >= 4'd14 && ext_rise[d]))); // R11

    AST_RATE_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      rate_pulse[d] |=> !rate_pulse[d]); // R10

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise[d] |=> !ext_rise[d]); // R8
  end
endmodule

bind baud_clock_sel baud_sel_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .timer_tick(timer_tick),
  .dir_code  (dir_code),
  .rate_pulse(rate_pulse),
  .ext_rise  (ext_rise),
  .bit_en    (bit_en),
  .x1_mode   (x1_mode)
);

// File: tb/tb_baud_clock_sel.sv
module tb_baud_clock_sel;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] sel_ch0, sel_ch1;
  logic       set_alt, ext_mode1, ext_mode2, timer_tick;
  logic [3:0] ext_clk;
  logic [3:0] bit_en, x1_mode;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cnt [4];

  localparam int WATCHDOG = 150000;
  // 9216 cycles: expected pulses = baud/100 = half_baud/200
  localparam int WIN = 9216;

  typedef struct packed {
    logic [7:0]  s0;
    logic [7:0]  s1;
    logic        alt;
    logic        m1;
    logic        m2;
    int unsigned tag;
    int unsigned h0;
    int unsigned h1;
    int unsigned h2;
    int unsigned h3;
  } vec_t;

  // expected rates as twice the baud value, per direction 0..3
  localparam vec_t VECS [6] = '{
    '{8'hC0, 8'hB6, 1'b0, 1'b0, 1'b0, 3, 76800,    100, 19200,   2400},
    '{8'hC0, 8'hA7, 1'b1, 1'b0, 1'b0, 4, 38400,    150,  3600,   4000},
    '{8'hC3, 8'h9A, 1'b0, 1'b1, 1'b0, 5, 460800,  2400, 57600,  14400},
    '{8'hC0, 8'hB2, 1'b1, 1'b1, 1'b0, 5, 230400,   900, 115200,   269},
    '{8'h21, 8'h8A, 1'b0, 1'b0, 1'b1, 6, 2152,    1760, 115200, 115200},
    '{8'h3C, 8'hA0, 1'b1, 1'b1, 1'b1, 6, 28800,  38400, 28800,  14400}
  };

  baud_clock_sel dut (
    .clk(clk), .rst_n(rst_n), .sel_ch0(sel_ch0), .sel_ch1(sel_ch1),
    .set_alt(set_alt), .ext_mode1(ext_mode1), .ext_mode2(ext_mode2),
    .timer_tick(timer_tick), .ext_clk(ext_clk),
    .bit_en(bit_en), .x1_mode(x1_mode)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      errors++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < %0d", cyc, WATCHDOG);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_count(input int n);
    for (int d = 0; d < 4; d++) cnt[d] = 0;
    repeat (n) begin
      @(negedge clk);
      for (int d = 0; d < 4; d++) cnt[d] += int'(bit_en[d]);
    end
  endtask

  task automatic check_rate(input int d, input int unsigned h, input int unsigned tag);
    int lo;
    lo = cnt[d] * 200;
    check((lo + 199 >= int'(h)) && (lo <= int'(h) + 199),
          $sformatf("R%0d dir%0d rate", tag, d), cnt[d], int'(h) / 200);
  endtask

  // pulse pin p n times, count pulses over the whole burst plus trailer
  task automatic pin_burst(input int p, input int n);
    for (int d = 0; d < 4; d++) cnt[d] = 0;
    for (int k = 0; k < n; k++) begin
      ext_clk[p] = 1'b1;
      repeat (3) begin @(negedge clk); for (int d = 0; d < 4; d++) cnt[d] += int'(bit_en[d]); end
      ext_clk[p] = 1'b0;
      repeat (3) begin @(negedge clk); for (int d = 0; d < 4; d++) cnt[d] += int'(bit_en[d]); end
    end
    repeat (6) begin @(negedge clk); for (int d = 0; d < 4; d++) cnt[d] += int'(bit_en[d]); end
  endtask

  initial begin
    rst_n = 1'b0; sel_ch0 = 8'hDD; sel_ch1 = 8'hDD;
    set_alt = 1'b0; ext_mode1 = 1'b0; ext_mode2 = 1'b0;
    timer_tick = 1'b1; ext_clk = 4'hF;

    // R1: reset holds outputs low
    repeat (4) @(negedge clk);
    check(bit_en == 4'h0, "R1 bit_en in reset", bit_en, 0);
    check(x1_mode == 4'h0, "R1 x1_mode in reset", x1_mode, 0);
    timer_tick = 1'b0; ext_clk = 4'h0;
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R7: timer pass-through with one cycle latency
    timer_tick = 1'b1;
    @(negedge clk);
    check(bit_en == 4'hF, "R7 timer tick passed", bit_en, 15);
    timer_tick = 1'b0;
    @(negedge clk);
    check(bit_en == 4'h0, "R7 timer tick gone", bit_en, 0);

    // rate table vectors (R2 R3 R4 R5 R6 R10)
    foreach (VECS[i]) begin
      sel_ch0 = VECS[i].s0; sel_ch1 = VECS[i].s1;
      set_alt = VECS[i].alt; ext_mode1 = VECS[i].m1; ext_mode2 = VECS[i].m2;
      repeat (4) @(negedge clk);
      run_count(WIN);
      check_rate(0, VECS[i].h0, VECS[i].tag);
      check_rate(1, VECS[i].h1, VECS[i].tag);
      check_rate(2, VECS[i].h2, VECS[i].tag);
      check_rate(3, VECS[i].h3, VECS[i].tag);
    end

    // R8: 16x pin, one pulse per rising edge, only on its own direction (R2)
    sel_ch0 = 8'hEE; sel_ch1 = 8'hEE; ext_clk = 4'h0;
    repeat (4) @(negedge clk);
    check(x1_mode == 4'h0, "R9 x1_mode low for code 14", x1_mode, 0);
    pin_burst(0, 5);
    check(cnt[0] == 5, "R8 pin0 edges", cnt[0], 5);
    check(cnt[1] + cnt[2] + cnt[3] == 0, "R2 pin0 leaks", cnt[1] + cnt[2] + cnt[3], 0);
    pin_burst(2, 3);
    check(cnt[2] == 3, "R2 pin2 edges", cnt[2], 3);
    check(cnt[0] + cnt[1] + cnt[3] == 0, "R2 pin2 leaks", cnt[0] + cnt[1] + cnt[3], 0);
    ext_clk[1] = 1'b1;
    run_count(24);
    check(cnt[1] == 1, "R8 held pin one pulse", cnt[1], 1);
    ext_clk[1] = 1'b0;
    repeat (4) @(negedge clk);

    // R9: 1x code
    sel_ch0 = 8'hFF; sel_ch1 = 8'hFF;
    @(negedge clk);
    check(x1_mode == 4'hF, "R9 x1_mode for code 15", x1_mode, 15);
    pin_burst(3, 4);
    check(cnt[3] == 4, "R9 pin3 edges at 1x", cnt[3], 4);
    sel_ch1 = 8'hFE;
    @(negedge clk);
    check(x1_mode == 4'b0111, "R9 x1_mode per nibble", x1_mode, 7);

    // R11: switch away from a busy timer source
    sel_ch0 = 8'hDD; sel_ch1 = 8'hDD; timer_tick = 1'b1;
    repeat (2) @(negedge clk);
    check(bit_en == 4'hF, "R11 timer busy before switch", bit_en, 15);
    sel_ch0 = 8'hEE;
    @(negedge clk);
    check(bit_en == 4'b1100, "R11 new source at next edge", bit_en, 12);
    run_count(8);
    check(cnt[0] + cnt[1] == 0, "R11 no carry-over", cnt[0] + cnt[1], 0);
    timer_tick = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule